// File: doc/BRIEF.md
# Dual-Edge Sample Capture Interleaver

This block samples an 8-bit input twice per clock period: once on the rising edge and once on the falling edge. A frame counter runs from 0 to 99 and then wraps. It sets where each rising-edge sample goes, and the falling edge that follows writes to the same slot in a second store. Each frame therefore holds 100 rising-edge samples and 100 falling-edge samples.

Readout is a plain combinational index map over both stores. A read index from 0 to 199 returns the samples in true time order: rising, falling, rising, falling. A steadily rising input therefore reads back as a steadily rising sequence. The block does not need a doubled clock. A one-cycle done pulse marks the point where a whole frame has been captured.

Top module: `dual_edge_interleaver`

## Requirements
- R1: A synchronous active-high reset, sampled on the rising edge for the counter, rising store and done flag and on the falling edge for the falling store, clears all of them. Afterwards every read index returns 0 and `frame_done` is 0.
- R2: On each rising edge the input is written to rising-store slot k, where k is the counter value. The counter then advances k to k+1, and from 99 it wraps to 0.
- R3: On each falling edge the input is written to falling-store slot k, where k is the slot written by the rising edge just before it.
- R4: Read index i returns rising-store slot i/2 when i is even and falling-store slot i/2 when i is odd. A frame fed with the values 1, 2, 3, ... in time order reads back as i+1 at index i.
- R5: `frame_done` is high for exactly one cycle. It is set by the rising edge that follows the falling-edge capture into slot 99. This happens once per 100-period frame.
- R6: A read index of 200 or more returns 0.
- R7: A reset in the middle of a frame restarts capture at slot 0 and clears any slots written before the reset.
- R8: `rd_data` follows `rd_idx` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges capture |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Sample input |
| rd_idx | input | 8 | Interleaved read position, 0 to 199 |
| rd_data | output | 8 | Sample at `rd_idx` |
| frame_done | output | 1 | One-cycle pulse after a full frame |

## Verification
The done pulse and the first rising-edge capture of the next frame fall on the same rising edge, so that edge both reports a finished frame and overwrites rising slot 0. The bench reads all 200 positions in the half period before that edge. It then checks that the pulse occurs exactly once across the following frame, which is fed a different pattern, and it reads that second frame back against its own expected interleaving. A mid-frame reset is provoked and judged by reading slots that had been written before the reset and must now read 0.

// File: rtl/dual_edge_interleaver.sv
`timescale 1ns/1ps
module dual_edge_interleaver #(
  parameter int W = 8,
  parameter int N = 100,
  localparam int CW = $clog2(N),
  localparam int RW = $clog2(2*N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [RW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic          frame_done
);

  logic [W-1:0]  rise_mem [N];
  logic [W-1:0]  fall_mem [N];
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_slot;

  wire last = (cnt == CW'(N-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      last_slot  <= '0;
      frame_done <= 1'b0;
      for (int k = 0; k < N; k++) rise_mem[k] <= '0;
    end else begin
      rise_mem[cnt] <= din;
      last_slot     <= cnt;
      cnt           <= last ? '0 : cnt + 1'b1;
      frame_done    <= (last_slot == CW'(N-1));
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) fall_mem[k] <= '0;
    end else begin
      fall_mem[last_slot] <= din;
    end
  end

  wire [CW-1:0] slot     = rd_idx[RW-1:1];
  wire          in_range = (rd_idx < RW'(2*N));

  assign rd_data = !in_range ? '0 :
                   rd_idx[0] ? fall_mem[slot] : rise_mem[slot];

endmodule

// File: rtl/dual_edge_interleaver_chk.sv
`timescale 1ns/1ps
module dual_edge_interleaver_chk #(
  parameter int W = 8,
  parameter int N = 100,
  localparam int CW = $clog2(N),
  localparam int RW = $clog2(2*N)
) (
  input logic          clk,
  input logic          rst,
  input logic [CW-1:0] cnt,
  input logic          frame_done,
  input logic [RW-1:0] rd_idx,
  input logic [W-1:0]  rd_data
);

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (cnt == '0 && !frame_done));

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt < CW'(N));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(N-1)) |=> (cnt == '0));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != CW'(N-1)) |=> (cnt == $past(cnt) + 1'b1));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R5
  done_place_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (cnt == CW'(1)));

  // R6
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_idx >= RW'(2*N)) |-> (rd_data == '0));

endmodule

bind dual_edge_interleaver dual_edge_interleaver_chk #(.W(W), .N(N)) chk_i (
  .clk(clk), .rst(rst), .cnt(cnt), .frame_done(frame_done),
  .rd_idx(rd_idx), .rd_data(rd_data)
);

// File: tb/dual_edge_interleaver_test.sv
`timescale 1ns/1ps
module dual_edge_interleaver_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       frame_done;
  int checks = 0, failures = 0;
  int done_seen;

  dual_edge_interleaver uut (
    .clk(clk), .rst(rst), .din(din), .rd_idx(rd_idx),
    .rd_data(rd_data), .frame_done(frame_done)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    rst = 1'b0;
  endtask

  // din=r at the rising edge, din=f at the falling edge
  task automatic push(logic [7:0] r, logic [7:0] f);
    din = r;
    @(posedge clk); #1;
    if (frame_done) done_seen++;
    #1 din = f;
    @(negedge clk); #2;
  endtask

  function automatic logic [7:0] f2(int p);
    return (p % 2 == 0) ? 8'(3*(p/2) + 7) : 8'(255 - p/2);
  endfunction

  task automatic test_reset();
    int bad = 0;
    do_reset();
    for (int i = 0; i < 200; i++) begin
      rd_idx = 8'(i); #0.005;
      if (rd_data != 0) bad++;
    end
    chk("R1 nonzero slots after reset", bad, 0);
    chk("R1 frame_done after reset", int'(frame_done), 0);
  endtask

  task automatic test_ramp();
    int bad = 0;
    done_seen = 0;
    for (int k = 0; k < 100; k++) push(8'(2*k+1), 8'(2*k+2));
    chk("R5 no done during first frame", done_seen, 0);
    // all 200 reads inside the half period before the next rising edge
    for (int i = 0; i < 200; i++) begin
      rd_idx = 8'(i); #0.005;
      if (rd_data != 8'(i+1)) begin
        bad++;
        chk("R4 ramp readout", int'(rd_data), i+1);
      end
    end
    chk("R4 R8 ramp mismatches", bad, 0);
    rd_idx = 8'd1; #0.005;
    chk("R3 falling slot 0", int'(rd_data), 2);
    rd_idx = 8'd198; #0.005;
    chk("R2 rising slot 99", int'(rd_data), 199);
    rd_idx = 8'd199; #0.005;
    chk("R3 falling slot 99", int'(rd_data), 200);
  endtask

  task automatic test_second_frame();
    int bad = 0;
    done_seen = 0;
    for (int k = 0; k < 100; k++) begin
      push(f2(2*k), f2(2*k+1));
      if (k == 0) chk("R5 done at first edge of next frame", done_seen, 1);
    end
    chk("R5 exactly one done pulse per frame", done_seen, 1);
    for (int i = 0; i < 200; i++) begin
      rd_idx = 8'(i); #0.005;
      if (rd_data != f2(i)) bad++;
    end
    chk("R2 R3 R4 second frame mismatches", bad, 0);
    @(posedge clk); #1;
    chk("R5 done pulse at frame end", int'(frame_done), 1);
    @(posedge clk); #1;
    chk("R5 done lasts one cycle", int'(frame_done), 0);
    @(negedge clk); #2;
  endtask

  task automatic test_out_of_range();
    rd_idx = 8'd200; #0.005;
    chk("R6 index 200", int'(rd_data), 0);
    rd_idx = 8'd255; #0.005;
    chk("R6 index 255", int'(rd_data), 0);
  endtask

  task automatic test_mid_reset();
    for (int k = 0; k < 30; k++) push(8'hC0, 8'hC1);
    do_reset();
    push(8'h11, 8'h22);
    rd_idx = 8'd0; #0.005;
    chk("R7 restart rising slot 0", int'(rd_data), 8'h11);
    rd_idx = 8'd1; #0.005;
    chk("R7 restart falling slot 0", int'(rd_data), 8'h22);
    rd_idx = 8'd40; #0.005;
    chk("R7 old rising slot cleared", int'(rd_data), 0);
    rd_idx = 8'd41; #0.005;
    chk("R7 old falling slot cleared", int'(rd_data), 0);
  endtask

  initial begin
    test_reset();
    test_ramp();
    test_second_frame();
    test_out_of_range();
    test_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100us;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule